// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is the digital controller for an eight-input successive-approximation converter. Software programs it through a small register port: a control word holds a channel mask, a clock divide value, a continuous-scan enable and a three-bit trigger code. The block makes a converter clock enable from the bus clock. It runs either a single conversion on request or an endless scan over the enabled inputs. Toward the analog side it drives the channel number being converted and a one-hot strobe that marks which result bit is being decided.

The comparator and the internal DAC are not part of this block. A test input, `test_sample`, stands in for the converted value and is captured when a conversion finishes. Each input has its own result word with a fresh-data flag and a lost-data flag. A global result word follows every completed conversion and also reports the channel number.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000001 (mask 0x01, divide 0, scan off, trigger 000). No conversion is running. Every result word reads zero.
- R2: `adc_clk_en` comes from a free-running counter that restarts at 0 in the cycle after it reaches the divide value (control bits 15:8). The enable is high in that reaching cycle, so it pulses once every divide+1 cycles and is high in every cycle when the divide value is 0.
- R3: A conversion lasts 11 enable pulses. On pulse k (k = 1..10) `bit_strobe` bit 10-k becomes the single high bit, so the strobe walks from bit 9 down to bit 0. On the 11th pulse `test_sample` is captured, and `conv_busy` falls unless the scan continues. `bit_strobe` is zero whenever no strobe bit is due.
- R4: A write to address 0 with bit 16 = 0 and bits 26:24 = 001 starts one conversion on the lowest set mask bit (control bits 7:0, bit i = input i). `conv_busy` rises at the second clock edge after the write. The request is ignored while a conversion is running.
- R5: A mask of zero behaves as mask 0x01: the conversion uses input 0.
- R6: With bit 16 set and bits 26:24 = 000, conversions repeat without pause. The first one uses the lowest set mask bit. Each later one uses the next higher set bit, and the scan wraps to the lowest set bit after the highest.
- R7: If bit 16 is cleared during a scan, the conversion in flight still finishes and stores its result. No new conversion starts after it.
- R8: With bit 16 set and a nonzero trigger code, no conversion starts.
- R9: The result word of input c sits at address 8+c: result in bits 9:0 and done flag in bit 31. It holds the most recent result of input c. A read clears its done flag and its overrun flag in the read cycle, unless a capture to that input happens in the same cycle.
- R10: Bit 30 of a channel word (overrun) is set when a capture overwrites a result whose done flag was still set.
- R11: The global word at address 1 shows the done flag in bit 31, the channel number in bits 18:16 and the result in bits 9:0. It is updated by every capture, and a read clears its done flag.
- R12: The control word at address 0 reads back the trigger code in bits 26:24, the scan enable in bit 16, the divide value in bits 15:8 and the mask in bits 7:0. Writes to any other address change nothing, and addresses 2 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears flags of the addressed word) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| test_sample | input | 10 | Stand-in for the converted value |
| adc_clk_en | output | 1 | Converter clock enable |
| conv_busy | output | 1 | A conversion is in progress |
| conv_chan | output | 3 | Input being converted (holds the last one when idle) |
| bit_strobe | output | 10 | One-hot marker of the result bit being decided |

## Verification
The assertions check on every cycle that the strobe is one-hot or zero and silent when idle, and that the channel output does not move during a conversion. They also check that an undivided clock enables every cycle, that a nonzero trigger code keeps the scan idle, that a zero mask picks input 0, and that a capture sets the global done flag and ends an idle-bound conversion. The scan order over sparse masks, wrap-around, the finish-after-clear behaviour, and the overrun and read-clear interplay depend on histories of many conversions. Only the bench scenarios show them, with a behavioural model compared cycle by cycle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int NCH      = 8;
  localparam int CH_W     = $clog2(NCH);
  localparam int RES_W    = 10;
  localparam int DIV_W    = 8;
  localparam int TRIG_W   = 3;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;

  // word map
  localparam int A_CTRL   = 0;
  localparam int A_GLOB   = 1;
  localparam int A_CHBASE = 8;

  // field positions
  localparam int MASK_LSB  = 0;
  localparam int DIV_LSB   = 8;
  localparam int BURST_BIT = 16;
  localparam int TRIG_LSB  = 24;
  localparam int CHAN_LSB  = 16;
  localparam int OVR_BIT   = 30;
  localparam int DONE_BIT  = 31;

  localparam logic [TRIG_W-1:0] TRIG_NOW = 3'b001;

  typedef struct packed {
    logic [TRIG_W-1:0] trig;
    logic              burst;
    logic [DIV_W-1:0]  div;
    logic [NCH-1:0]    mask;
  } ctrl_t;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W = adc_scan_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= div);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int NCH   = adc_scan_pkg::NCH,
  parameter int RES_W = adc_scan_pkg::RES_W,
  localparam int CH_W  = $clog2(NCH),
  localparam int CNT_W = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go,
  input  logic             scan_run,
  input  logic [NCH-1:0]   mask,
  output logic             busy,
  output logic [CH_W-1:0]  chan,
  output logic [CNT_W-1:0] cnt,
  output logic [RES_W-1:0] strobe,
  output logic             cap
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RES_W);

  logic             busy_q, busy_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NCH-1:0]   eff_mask;
  logic [CH_W-1:0]  lowest, above;
  logic             above_ok;

  // effective mask and channel search (lowest set bit, next set bit above current)
  always_comb begin
    eff_mask = (mask == '0) ? NCH'(1) : mask;
    lowest   = '0;
    above    = '0;
    above_ok = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (eff_mask[i]) begin
        lowest = CH_W'(i);
        if (i > int'(chan_q)) begin
          above    = CH_W'(i);
          above_ok = 1'b1;
        end
      end
    end
  end

  always_comb begin
    busy_d = busy_q;
    chan_d = chan_q;
    cnt_d  = cnt_q;
    cap    = 1'b0;
    if (!busy_q) begin
      if (go || scan_run) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        chan_d = lowest;
      end
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cap   = 1'b1;
        cnt_d = '0;
        if (scan_run) chan_d = above_ok ? above : lowest;
        else          busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      chan_q <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      chan_q <= chan_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar b = 0; b < RES_W; b++) begin : g_strobe
    assign strobe[b] = busy_q && (cnt_q == CNT_W'(RES_W - b));
  end

  assign busy = busy_q;
  assign chan = chan_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH    = adc_scan_pkg::NCH,
  parameter int RES_W  = adc_scan_pkg::RES_W,
  parameter int ADDR_W = adc_scan_pkg::ADDR_W,
  localparam int CH_W  = $clog2(NCH),
  localparam int DW    = adc_scan_pkg::DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap,
  input  logic [CH_W-1:0]          cap_chan,
  input  logic [RES_W-1:0]         sample,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  output logic [NCH-1:0][DW-1:0]   ch_word,
  output logic [DW-1:0]            glob_word,
  output logic                     glob_done
);
  import adc_scan_pkg::*;

  // per-channel result storage
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [RES_W-1:0] res_q, res_d;
    logic             done_q, done_d, ovr_q, ovr_d;
    logic             rd_hit, cap_hit;

    assign rd_hit  = rd_en && (addr == ADDR_W'(A_CHBASE + c));
    assign cap_hit = cap && (cap_chan == CH_W'(c));

    always_comb begin
      res_d  = res_q;
      done_d = done_q;
      ovr_d  = ovr_q;
      if (rd_hit) begin
        done_d = 1'b0;
        ovr_d  = 1'b0;
      end
      if (cap_hit) begin
        res_d  = sample;
        done_d = 1'b1;
        ovr_d  = ovr_d | done_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q  <= '0;
        done_q <= 1'b0;
        ovr_q  <= 1'b0;
      end else begin
        res_q  <= res_d;
        done_q <= done_d;
        ovr_q  <= ovr_d;
      end
    end

    always_comb begin
      ch_word[c]           = '0;
      ch_word[c][RES_W-1:0] = res_q;
      ch_word[c][OVR_BIT]  = ovr_q;
      ch_word[c][DONE_BIT] = done_q;
    end
  end

  // global result word
  logic [RES_W-1:0] g_res_q, g_res_d;
  logic [CH_W-1:0]  g_chan_q, g_chan_d;
  logic             g_done_q, g_done_d;

  always_comb begin
    g_res_d  = g_res_q;
    g_chan_d = g_chan_q;
    g_done_d = g_done_q;
    if (rd_en && (addr == ADDR_W'(A_GLOB))) g_done_d = 1'b0;
    if (cap) begin
      g_res_d  = sample;
      g_chan_d = cap_chan;
      g_done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_res_q  <= '0;
      g_chan_q <= '0;
      g_done_q <= 1'b0;
    end else begin
      g_res_q  <= g_res_d;
      g_chan_q <= g_chan_d;
      g_done_q <= g_done_d;
    end
  end

  always_comb begin
    glob_word                          = '0;
    glob_word[RES_W-1:0]               = g_res_q;
    glob_word[CHAN_LSB +: CH_W]        = g_chan_q;
    glob_word[DONE_BIT]                = g_done_q;
  end

  assign glob_done = g_done_q;
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [RES_W-1:0]  test_sample,
  output logic              adc_clk_en,
  output logic              conv_busy,
  output logic [CH_W-1:0]   conv_chan,
  output logic [RES_W-1:0]  bit_strobe
);
  localparam int CNT_W = $clog2(RES_W + 1);

  ctrl_t ctrl_q, ctrl_d;
  logic  go_q, go_d;
  logic  ctrl_wr;

  // control word and single-shot request
  always_comb begin
    ctrl_wr = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
    ctrl_d  = ctrl_q;
    go_d    = 1'b0;
    if (ctrl_wr) begin
      ctrl_d.mask  = bus_wdata[MASK_LSB +: NCH];
      ctrl_d.div   = bus_wdata[DIV_LSB +: DIV_W];
      ctrl_d.burst = bus_wdata[BURST_BIT];
      ctrl_d.trig  = bus_wdata[TRIG_LSB +: TRIG_W];
      go_d = !bus_wdata[BURST_BIT] && (bus_wdata[TRIG_LSB +: TRIG_W] == TRIG_NOW);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{trig: '0, burst: 1'b0, div: '0, mask: NCH'(1)};
      go_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      go_q   <= go_d;
    end
  end

  logic [NCH-1:0]    ctrl_mask;
  logic [DIV_W-1:0]  ctrl_div;
  logic              ctrl_burst;
  logic [TRIG_W-1:0] ctrl_trig;
  logic              scan_run;

  assign ctrl_mask  = ctrl_q.mask;
  assign ctrl_div   = ctrl_q.div;
  assign ctrl_burst = ctrl_q.burst;
  assign ctrl_trig  = ctrl_q.trig;
  assign scan_run   = ctrl_burst && (ctrl_trig == '0);

  logic             tick;
  logic [CNT_W-1:0] seq_cnt;
  logic             cap;

  adc_clk_div #(.DIV_W(DIV_W)) i_div (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (ctrl_div),
    .tick (tick)
  );

  adc_conv_seq #(.NCH(NCH), .RES_W(RES_W)) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .go      (go_q),
    .scan_run(scan_run),
    .mask    (ctrl_mask),
    .busy    (conv_busy),
    .chan    (conv_chan),
    .cnt     (seq_cnt),
    .strobe  (bit_strobe),
    .cap     (cap)
  );

  logic [NCH-1:0][DATA_W-1:0] ch_word;
  logic [DATA_W-1:0]          glob_word;
  logic                       glob_done;

  adc_result_bank #(.NCH(NCH), .RES_W(RES_W), .ADDR_W(ADDR_W)) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (cap),
    .cap_chan (conv_chan),
    .sample   (test_sample),
    .rd_en    (bus_rd),
    .addr     (bus_addr),
    .ch_word  (ch_word),
    .glob_word(glob_word),
    .glob_done(glob_done)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CTRL)) begin
      bus_rdata[MASK_LSB +: NCH]     = ctrl_mask;
      bus_rdata[DIV_LSB +: DIV_W]    = ctrl_div;
      bus_rdata[BURST_BIT]           = ctrl_burst;
      bus_rdata[TRIG_LSB +: TRIG_W]  = ctrl_trig;
    end else if (bus_addr == ADDR_W'(A_GLOB)) begin
      bus_rdata = glob_word;
    end else if (bus_addr >= ADDR_W'(A_CHBASE)) begin
      bus_rdata = ch_word[CH_W'(bus_addr - ADDR_W'(A_CHBASE))];
    end
  end

  assign adc_clk_en = tick;
endmodule

// File: rtl/adc_scan_checker.sv
module adc_scan_checker #(
  parameter int NCH   = adc_scan_pkg::NCH,
  parameter int RES_W = adc_scan_pkg::RES_W,
  parameter int DIV_W = adc_scan_pkg::DIV_W,
  localparam int CH_W = $clog2(NCH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [CH_W-1:0]  chan,
  input logic [RES_W-1:0] strobe,
  input logic             clk_en,
  input logic [DIV_W-1:0] div,
  input logic [NCH-1:0]   mask,
  input logic             burst,
  input logic [2:0]       trig,
  input logic             go,
  input logic             cap,
  input logic             glob_done
);
  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));

  p_strobe_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (strobe == '0));

  p_undivided_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |-> clk_en);

  p_chan_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cap) |=> $stable(chan));

  p_trig_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && burst && (trig != 3'b000) && !go) |=> !busy);

  p_zero_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (mask == '0) && (go || (burst && trig == 3'b000))) |=> (busy && chan == '0));

  p_stop_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !(burst && trig == 3'b000)) |=> !busy);

  p_glob_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> glob_done);
endmodule

bind adc_scan_ctrl adc_scan_checker i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (conv_busy),
  .chan     (conv_chan),
  .strobe   (bit_strobe),
  .clk_en   (adc_clk_en),
  .div      (ctrl_div),
  .mask     (ctrl_mask),
  .burst    (ctrl_burst),
  .trig     (ctrl_trig),
  .go       (go_q),
  .cap      (cap),
  .glob_done(glob_done)
);

// File: tb/test_adc_scan_ctrl.sv
`timescale 1ns/1ps
module test_adc_scan_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [9:0]  test_sample = '0;
  logic        adc_clk_en, conv_busy;
  logic [2:0]  conv_chan;
  logic [9:0]  bit_strobe;

  int errors = 0, checks = 0;
  bit done_run = 0;
  bit ramp = 0;

  always #2.5 clk = ~clk;

  adc_scan_ctrl i_adc_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .test_sample(test_sample), .adc_clk_en(adc_clk_en), .conv_busy(conv_busy),
    .conv_chan(conv_chan), .bit_strobe(bit_strobe)
  );

  // ---------------- behavioural reference ----------------
  int m_divcnt, m_cnt, m_chan, m_busy, m_go;
  int m_mask, m_div, m_burst, m_trig;
  int m_res[8], m_done[8], m_ovr[8];
  int g_res, g_chan, g_done;

  function automatic int pick(int mask, int cur);
    int m = (mask == 0) ? 1 : mask;
    for (int i = cur + 1; i < 8; i++) if (m[i]) return i;
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] exp_rdata(int a);
    logic [31:0] w = '0;
    if (a == 0) begin
      w[7:0] = m_mask[7:0]; w[15:8] = m_div[7:0]; w[16] = m_burst[0]; w[26:24] = m_trig[2:0];
    end else if (a == 1) begin
      w[9:0] = g_res[9:0]; w[18:16] = g_chan[2:0]; w[31] = g_done[0];
    end else if (a >= 8) begin
      w[9:0] = m_res[a-8][9:0]; w[30] = m_ovr[a-8][0]; w[31] = m_done[a-8][0];
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_divcnt = 0; m_cnt = 0; m_chan = 0; m_busy = 0; m_go = 0;
      m_mask = 1; m_div = 0; m_burst = 0; m_trig = 0;
      for (int c = 0; c < 8; c++) begin m_res[c] = 0; m_done[c] = 0; m_ovr[c] = 0; end
      g_res = 0; g_chan = 0; g_done = 0;
    end else begin
      bit tick, run, cap;
      int cc, old_done;
      tick = (m_divcnt >= m_div);
      run  = (m_burst != 0) && (m_trig == 0);
      cap  = 0; cc = m_chan;
      if (m_busy == 0) begin
        if (m_go != 0 || run) begin m_busy = 1; m_cnt = 0; m_chan = pick(m_mask, 7); end
      end else if (tick) begin
        if (m_cnt == 10) begin
          cap = 1; m_cnt = 0;
          if (run) m_chan = pick(m_mask, m_chan); else m_busy = 0;
        end else m_cnt++;
      end
      if (bus_rd && bus_addr == 1) g_done = 0;
      if (cap) begin
        old_done = m_done[cc];
        if (bus_rd && bus_addr == 4'(8 + cc)) begin m_done[cc] = 0; m_ovr[cc] = 0; end
        m_res[cc] = test_sample; m_done[cc] = 1; m_ovr[cc] = m_ovr[cc] | old_done;
        g_res = test_sample; g_chan = cc; g_done = 1;
      end
      if (bus_rd && bus_addr >= 8 && !(cap && bus_addr == 4'(8 + cc))) begin
        m_done[bus_addr-8] = 0; m_ovr[bus_addr-8] = 0;
      end
      m_go = 0;
      if (bus_wr && bus_addr == 0) begin
        m_mask = bus_wdata[7:0]; m_div = bus_wdata[15:8];
        m_burst = bus_wdata[16]; m_trig = bus_wdata[26:24];
        m_go = (!bus_wdata[16] && bus_wdata[26:24] == 3'b001) ? 1 : 0;
      end
      m_divcnt = tick ? 0 : m_divcnt + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      logic [9:0] es;
      es = '0;
      if (m_busy != 0 && m_cnt >= 1) es[10 - m_cnt] = 1'b1;
      chk("R2 clk_en", 32'(adc_clk_en), 32'(m_divcnt >= m_div));
      chk("R3 strobe", 32'(bit_strobe), 32'(es));
      chk("R4 busy", 32'(conv_busy), 32'(m_busy));
      chk("R6 chan", 32'(conv_chan), 32'(m_chan));
      chk("R9 rdata", bus_rdata, exp_rdata(int'(bus_addr)));
    end
  end

  always @(posedge clk) if (ramp) #1 test_sample = test_sample + 10'd37;

  // ---------------- stimulus ----------------
  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    step(); bus_wr = 1; bus_addr = a; bus_wdata = d;
    step(); bus_wr = 0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    step(); bus_rd = 1; bus_addr = a;
    @(negedge clk); chk(req, bus_rdata, exp);
    step(); bus_rd = 0;
  endtask

  task automatic idle(int n); repeat (n) step(); endtask

  initial begin
    int seen[$];
    int last;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 busy", 32'(conv_busy), 0);
    rd_chk("R1 ctrl", 4'd0, 32'h0000_0001);
    rd_chk("R1 glob", 4'd1, 32'h0);
    rd_chk("R1 ch3", 4'd11, 32'h0);

    // R4 single conversion, lowest of mask 0x24 -> input 2
    test_sample = 10'h2A5;
    wr(4'd0, 32'h0100_0024);
    idle(20);
    rd_chk("R9 ch2 done", 4'd10, 32'h8000_02A5);
    rd_chk("R11 glob", 4'd1, 32'h8002_02A5);
    rd_chk("R9 ch2 cleared", 4'd10, 32'h0000_02A5);
    rd_chk("R11 glob cleared", 4'd1, 32'h0002_02A5);

    // R5 zero mask, divided clock; R10 overrun
    test_sample = 10'h155;
    wr(4'd0, 32'h0100_0300);
    idle(60);
    chk("R3 finished", 32'(conv_busy), 0);
    wr(4'd0, 32'h0100_0300);
    idle(60);
    rd_chk("R10 ch0 overrun", 4'd8, 32'hC000_0155);
    rd_chk("R10 ch0 cleared", 4'd8, 32'h0000_0155);

    // R12 write to non-control address ignored
    wr(4'd3, 32'hFFFF_FFFF);
    rd_chk("R12 ctrl kept", 4'd0, 32'h0100_0300);
    rd_chk("R12 hole zero", 4'd5, 32'h0);

    // R8 burst with nonzero trigger: nothing starts
    wr(4'd0, 32'h0201_00FF);
    idle(50);
    chk("R8 no start", 32'(conv_busy), 0);

    // R6 burst scan over mask 0xA2, divide 1
    ramp = 1;
    wr(4'd0, 32'h0001_01A2);
    last = -1;
    repeat (110) begin
      @(negedge clk);
      if (conv_busy && int'(conv_chan) != last) begin seen.push_back(int'(conv_chan)); last = int'(conv_chan); end
    end
    chk("R6 count", 32'(seen.size() >= 4), 1);
    if (seen.size() >= 4) begin
      chk("R6 first", 32'(seen[0]), 1);
      chk("R6 second", 32'(seen[1]), 5);
      chk("R6 third", 32'(seen[2]), 7);
      chk("R6 wrap", 32'(seen[3]), 1);
    end
    // R7 clear burst mid-conversion
    step();
    chk("R7 busy at clear", 32'(conv_busy), 1);
    wr(4'd0, 32'h0000_01A2);
    idle(60);
    chk("R7 stopped", 32'(conv_busy), 0);
    idle(20);
    chk("R7 still idle", 32'(conv_busy), 0);
    ramp = 0;

    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule